// File: doc/BRIEF.md
# Wrap-Around Double to Int32 Converter

This block turns a 64-bit IEEE-754 binary64 value into a 32-bit signed integer the way a scripting-language integer coercion does. The fractional part is dropped toward zero, the integer part is reduced modulo 2^32, and the resulting bit pattern is read as two's complement. The converter never saturates. NaN, both infinities and magnitudes too large to leave any bit below 2^32 all yield zero.

Internally the block works out the unbiased exponent from the input. It then aligns the 53-bit significand, with its hidden one restored, so that the integer units land at bit 0, shifting left or right as the exponent requires. It keeps the low 32 bits and negates them when the sign bit is set. A parameter chooses between a purely combinational path and a single registered stage; the registered variant is the default. A one-bit valid strobe travels alongside the data.

Top module: `d2i_wrap32`

## Requirements
- R1: The sign is input bit 63, the biased exponent is bits 62:52 and the fraction is bits 51:0. The unbiased exponent e equals the biased exponent minus 1023, so 1.0 converts to 1.
- R2: When e < 0 or e > 83 the result is 0. This covers +0, -0, subnormals, magnitudes below one, values of 2^84 and above, infinities and NaN.
- R3: For 0 <= e <= 52, the magnitude is the significand with its hidden one restored and shifted right by 52 - e, keeping the low 32 bits. For example, 2^52 + 3 gives 3.
- R4: For 53 <= e <= 83, the magnitude is the significand shifted left by e - 52, keeping the low 32 bits. The low e - 52 bits of the magnitude are then zero; for example, 2^83 + 2^31 gives 0x80000000.
- R5: When the sign bit is set, the output is the two's-complement negation of the magnitude modulo 2^32. For example, -1.0 gives 0xFFFFFFFF.
- R6: Integer parts at or beyond 2^31 wrap modulo 2^32 without saturating. 2^31 and -2^31 both give 0x80000000, 2^32 gives 0, 2^32 + 5 gives 5, and 1e10 gives 0x540BE400.
- R7: Fractions are truncated toward zero, so 2.75 gives 2 and -2.75 gives 0xFFFFFFFE.
- R8: In the default registered variant, out_valid rises on the clock edge after in_valid is sampled high, and out_int carries that input's result in the same cycle. With in_valid low, out_valid is low in the next cycle and out_int holds its value. Reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_bits | input | 64 | binary64 value to convert |
| out_valid | output | 1 | out_int holds a fresh result |
| out_int | output | 32 | Converted 32-bit signed integer |

## Verification
Directed inputs are chosen at the exponent boundaries 0, 31, 32, 52, 53, 83 and 84. This separates the right-shift path from the left-shift path, finds off-by-one errors in the range limits, and shows whether the hidden one is restored or dropped. Signed pairs such as ±1, ±2.75, ±2^31 and -(2^53+6) exercise the negation on both shift paths. Zeros, a subnormal, infinity and NaN confirm that these values collapse to zero rather than producing bits derived from the fraction. A sweep of pseudo-random exponents between 1000 and 1120 is checked against a truncate-and-reduce model written in real arithmetic. Back-to-back and idle cycles confirm that each result is paired with its own input and that the output holds while idle.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
   localparam int DBL_W  = 64;
   localparam int EXP_W  = 11;
   localparam int FRAC_W = 52;
   localparam int BIAS   = 1023;

   typedef struct packed {
      logic              sgn;
      logic [EXP_W-1:0]  bexp;
      logic [FRAC_W-1:0] frac;
   } dbl_t;
endpackage

// File: rtl/d2i_exp_decode.sv
module d2i_exp_decode
   import d2i_pkg::*;
#(
   parameter int INT_W = 32,
   localparam int MAX_E = FRAC_W + INT_W - 1,
   localparam int AMT_W = $clog2(FRAC_W + 1)
) (
   input  logic [EXP_W-1:0] bexp,
   output logic             in_range,
   output logic             go_left,
   output logic [AMT_W-1:0] amt
);
   localparam int EW = EXP_W + 1;
   logic [EW-1:0] e_val;
   logic          below_one;

   always_comb begin
      e_val     = {1'b0, bexp} - EW'(BIAS);
      below_one = ({1'b0, bexp} < EW'(BIAS));
      in_range  = !below_one && (e_val <= EW'(MAX_E));
      go_left   = (e_val > EW'(FRAC_W));
      if (go_left) amt = AMT_W'(e_val - EW'(FRAC_W));
      else         amt = AMT_W'(EW'(FRAC_W) - e_val);
   end
endmodule

// File: rtl/d2i_align.sv
module d2i_align
   import d2i_pkg::*;
#(
   parameter int INT_W = 32,
   localparam int AMT_W = $clog2(FRAC_W + 1),
   localparam int WW    = FRAC_W + INT_W
) (
   input  logic [FRAC_W-1:0] frac,
   input  logic              in_range,
   input  logic              go_left,
   input  logic [AMT_W-1:0]  amt,
   output logic [INT_W-1:0]  mag
);
   logic [WW-1:0]    sig_wide;
   logic [WW-1:0]    up_sh;
   logic [WW-1:0]    dn_sh;
   logic [INT_W-1:0] low_mask;

   always_comb begin
      sig_wide = WW'({1'b1, frac});
      up_sh    = sig_wide << amt;
      dn_sh    = sig_wide >> amt;
      if (!in_range)    mag = '0;
      else if (go_left) mag = up_sh[INT_W-1:0];
      else              mag = dn_sh[INT_W-1:0];
   end

   always_comb begin
      low_mask = (INT_W'(1) << amt) - INT_W'(1);
      if (in_range && go_left)
         assert_low_clear_R4: assert ((mag & low_mask) == '0)
            else $error("left-aligned magnitude has bits below the shift");
   end
endmodule

// File: rtl/d2i_sign.sv
module d2i_sign #(
   parameter int INT_W = 32
) (
   input  logic             neg,
   input  logic [INT_W-1:0] mag,
   output logic [INT_W-1:0] res
);
   always_comb res = neg ? (~mag + INT_W'(1)) : mag;
endmodule

// File: rtl/d2i_wrap32.sv
module d2i_wrap32
   import d2i_pkg::*;
#(
   parameter int INT_W   = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [63:0]      in_bits,
   output logic             out_valid,
   output logic [INT_W-1:0] out_int
);
   localparam int AMT_W = $clog2(FRAC_W + 1);
   localparam int MAX_E = FRAC_W + INT_W - 1;
   localparam int HI_BX = BIAS + MAX_E;

   if (INT_W < 2 || INT_W > 32)
      $error("INT_W must lie in 2..32");
   if (1 + EXP_W + FRAC_W != DBL_W || DBL_W != 64)
      $error("binary64 field widths are inconsistent");

   dbl_t             din;
   logic             in_range, go_left;
   logic [AMT_W-1:0] amt;
   logic [INT_W-1:0] mag, res;

   assign din = dbl_t'(in_bits);

   d2i_exp_decode #(.INT_W(INT_W)) u_dec (
      .bexp(din.bexp), .in_range(in_range), .go_left(go_left), .amt(amt)
   );

   d2i_align #(.INT_W(INT_W)) u_aln (
      .frac(din.frac), .in_range(in_range), .go_left(go_left),
      .amt(amt), .mag(mag)
   );

   d2i_sign #(.INT_W(INT_W)) u_sgn (
      .neg(din.sgn), .mag(mag), .res(res)
   );

   if (OUT_REG) begin : g_reg
      logic             v_q;
      logic [INT_W-1:0] r_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            r_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) r_q <= res;
         end
      end
      assign out_valid = v_q;
      assign out_int   = r_q;

      assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(out_int)));
      assert_range_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (in_bits[62:52] < 11'(BIAS) || in_bits[62:52] > 11'(HI_BX)))
         |=> (out_int == '0));
      assert_unit_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_bits[62:0] == {1'b0, 11'(BIAS), 52'd0})
         |=> (out_int == ($past(in_bits[63]) ? {INT_W{1'b1}} : INT_W'(1))));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_int   = res;

      always_comb begin
         if (in_valid && !in_range)
            assert_range_zero_R2: assert (out_int == '0)
               else $error("out-of-range input gave nonzero result");
      end
   end
endmodule

// File: tb/d2i_wrap32_test.sv
module d2i_wrap32_test;
   localparam time PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_bits = '0;
   logic        out_valid;
   logic [31:0] out_int;

   int    checks = 0;
   int    errs = 0;
   bit    done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] last_exp = '0;

   always #(PERIOD/2) clk = ~clk;

   d2i_wrap32 uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
      .out_valid(out_valid), .out_int(out_int)
   );

   function automatic logic [31:0] ref_model(input logic [63:0] b);
      real v, t, m;
      if (b[62:52] == 11'h7FF) return 32'd0;
      v = $bitstoreal(b);
      t = (v < 0.0) ? -$floor(-v) : $floor(v);
      m = t - 4294967296.0 * $floor(t / 4294967296.0);
      return 32'(longint'(m));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errs++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, expv);
      end
   endtask

   task automatic send(input logic [63:0] b, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_bits  = b;
      exp_q.push_back(ref_model(b));
      tag_q.push_back(tag);
      last_exp = ref_model(b);
   endtask

   task automatic send_r(input real v, input string tag);
      send($realtobits(v), tag);
   endtask

   // monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errs++;
            $display("FAIL R8: result 0x%08h with nothing expected", out_int);
         end else begin
            check(tag_q.pop_front(), out_int, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(PERIOD * 50000);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset valid", {31'd0, out_valid}, 32'd0);
      check("R8 reset data", out_int, 32'd0);
      rst_n = 1'b1;

      send_r(1.0, "R1 e=0");
      send_r(-1.0, "R5 negative one");
      send_r(2.75, "R7 truncate pos");
      send_r(-2.75, "R7 truncate neg");
      send_r(0.5, "R2 below one");
      send(64'h0000_0000_0000_0000, "R2 plus zero");
      send(64'h8000_0000_0000_0000, "R2 minus zero");
      send(64'h0000_0000_0000_0001, "R2 subnormal");
      send(64'h7FF0_0000_0000_0000, "R2 infinity");
      send(64'h7FF8_0000_0000_0000, "R2 nan");
      send_r(2.0**31, "R6 e=31");
      send_r(-(2.0**31), "R6 neg e=31");
      send_r(2147483647.9, "R3 max positive");
      send_r(2.0**32, "R6 e=32");
      send_r(2.0**32 + 5.0, "R6 wrap plus five");
      send_r(1.0e10, "R6 ten billion");
      send_r(2.0**52 + 3.0, "R3 e=52");
      send_r(2.0**53 + 2.0, "R4 e=53");
      send_r(-(2.0**53 + 6.0), "R4 neg e=53");
      send_r(2.0**83 + 2.0**31, "R4 e=83");
      send_r(2.0**84 + 2.0**32, "R2 e=84");
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 60; i++) begin
         logic [63:0] r;
         r = {$urandom(), $urandom()};
         r[62:52] = 11'(1000 + $urandom_range(120));
         send(r, "R3 sweep");
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);

      check("R8 idle valid", {31'd0, out_valid}, 32'd0);
      check("R8 idle hold", out_int, last_exp);
      check("R8 drained", 32'(exp_q.size()), 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule